// File: doc/BRIEF.md
# Configurable Watchdog Countdown Timer

This block is a watchdog timer that lives in one bank of an 8-bit configuration register space. Software arms it by writing a nonzero count into the count register. It stops the timer by writing zero. While the timer runs, a read of the same register returns the time still left. A prescaler turns a free-running clock-enable input into a one-second unit. In minute mode the prescaler divides that second by a further 60, and the count drops by one on each unit.

When the count reaches zero the block latches a trigger flag in its status register and holds the count at zero. It then signals the timeout in one of two ways. In level mode the active-low watchdog output is driven low until software clears the flag. In pulse mode the block instead sends a fixed-width low pulse onto a keyboard-reset line. Mouse and keyboard activity can each be enabled to reload the count with the last value written. A keyboard event can also be enabled to stop the timer.

Top module: `wdt_cfg_timer`

## Requirements
- R1: After reset the count, control and status registers all read 0, and both `wdt_n` and `kbrst_n` are high.
- R2: A write to address 0xF6 loads the count with the written value. A value of 1 to 255 runs the timer. A value of 0 stops it, and no timeout follows.
- R3: The count falls by one after every TICKS_PER_SEC asserted `tick_en` cycles. A read of 0xF6 returns the remaining count.
- R4: When the count steps from 1 to 0, bit 4 of the status register (0xF7) is set and the count stays at 0. In level mode (control bit 1 clear), `wdt_n` goes low in the same cycle and stays low.
- R5: Writing the status register with bit 4 at 0 clears the trigger flag and returns `wdt_n` high. Writing bit 4 as 1 neither sets nor clears the flag.
- R6: When control register (0xF5) bit 3 is set, the unit is a minute, so one count lasts 60 × TICKS_PER_SEC ticks.
- R7: When control bit 1 is set, a timeout leaves `wdt_n` high and drives `kbrst_n` low for exactly PULSE_LEN cycles.
- R8: A nonzero write while the timer runs reloads the count and restarts the prescaler phase.
- R9: Status bit 7 lets a `mouse_evt` pulse reload the count with the last value written to 0xF6. Status bit 6 does the same for `kbd_evt`. An event whose enable bit is clear has no effect on the count.
- R10: When control bit 2 is set, a `kbd_evt` pulse stops the running timer (count becomes 0) and no timeout follows. When control bit 2 is clear, `kbd_evt` does not stop the timer.
- R11: `cfg_rdata` presents the addressed register in the cycle after `cfg_rd`. Control bits and status bits other than bit 4 read back as written. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Base clock-enable for the prescaler |
| cfg_wr | input | 1 | Register write strobe |
| cfg_rd | input | 1 | Register read strobe |
| cfg_addr | input | 8 | Register address within the bank |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Registered read data |
| kbd_evt | input | 1 | Keyboard activity pulse |
| mouse_evt | input | 1 | Mouse activity pulse |
| wdt_n | output | 1 | Active-low level timeout output |
| kbrst_n | output | 1 | Active-low keyboard-reset pulse |

## Verification
The bench sweeps every count value through write and readback. It also runs counts 1 to 5 to expiry, reading the count after each second. An off-by-one in the prescaler or in the expiry compare would therefore show up as a wrong remaining value or an early or late flag.

Restart tests rewrite the count one tick before a second boundary. A design that kept the prescaler phase would then step one tick early. The pulse-mode test measures the `kbrst_n` width cycle by cycle, which catches a pulse one cycle long or short. It also checks that `wdt_n` never falls in that mode.

The event tests toggle each enable bit. A design that decoded the wrong status bit, or ignored the enable, would reload or stop the count when it should not.

// File: rtl/wdt_cfg_pkg.sv
package wdt_cfg_pkg;
  localparam logic [7:0] A_CNT  = 8'hF6;
  localparam logic [7:0] A_CTRL = 8'hF5;
  localparam logic [7:0] A_STAT = 8'hF7;
  localparam int CTL_MIN   = 3;
  localparam int CTL_KSTOP = 2;
  localparam int CTL_PULSE = 1;
  localparam int ST_MOUSE  = 7;
  localparam int ST_KBD    = 6;
  localparam int ST_TRIG   = 4;
  localparam int SEC_PER_MIN = 60;
endpackage

// File: rtl/wdt_prescale.sv
module wdt_prescale import wdt_cfg_pkg::*; #(
  parameter int TICKS_PER_SEC = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic run,
  input  logic minute,
  input  logic tick_en,
  output logic unit_tick
);
  localparam int PRE_W = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
  localparam int MIN_W = $clog2(SEC_PER_MIN);

  logic [PRE_W-1:0] pre_q;
  logic [MIN_W-1:0] min_q;
  logic sec_tick;

  assign sec_tick  = run && tick_en && (pre_q == PRE_W'(TICKS_PER_SEC - 1));
  assign unit_tick = sec_tick && (!minute || (min_q == MIN_W'(SEC_PER_MIN - 1)));

  always_ff @(posedge clk) begin
    if (rst || clr || !run) begin
      pre_q <= '0;
      min_q <= '0;
    end else if (tick_en) begin
      if (sec_tick) begin
        pre_q <= '0;
        if (!minute || min_q == MIN_W'(SEC_PER_MIN - 1)) min_q <= '0;
        else                                             min_q <= min_q + 1'b1;
      end else begin
        pre_q <= pre_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse #(
  parameter int PULSE_LEN = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic fire,
  output logic pulse_n
);
  localparam int PW = $clog2(PULSE_LEN + 1);
  logic [PW-1:0] left_q;

  always_ff @(posedge clk) begin
    if (rst)                left_q <= '0;
    else if (fire)          left_q <= PW'(PULSE_LEN);
    else if (left_q != '0)  left_q <= left_q - 1'b1;
  end

  assign pulse_n = (left_q == '0);
endmodule

// File: rtl/wdt_cfg_timer.sv
module wdt_cfg_timer import wdt_cfg_pkg::*; #(
  parameter int TICKS_PER_SEC = 1000,
  parameter int PULSE_LEN     = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick_en,
  input  logic       cfg_wr,
  input  logic       cfg_rd,
  input  logic [7:0] cfg_addr,
  input  logic [7:0] cfg_wdata,
  output logic [7:0] cfg_rdata,
  input  logic       kbd_evt,
  input  logic       mouse_evt,
  output logic       wdt_n,
  output logic       kbrst_n
);
  logic [7:0] cnt_q, cnt_d, load_q, ctrl_q, ctrl_d, stat_q, stat_d, rdata_q, rd_mux;
  logic trig_q, trig_d, wdt_n_q;
  logic wr_cnt, wr_ctrl, wr_stat, running, reload_evt, kbd_stop, unit_tick, expire;

  assign wr_cnt  = cfg_wr && (cfg_addr == A_CNT);
  assign wr_ctrl = cfg_wr && (cfg_addr == A_CTRL);
  assign wr_stat = cfg_wr && (cfg_addr == A_STAT);
  assign running = (cnt_q != 8'd0);
  assign reload_evt = running && ((stat_q[ST_MOUSE] && mouse_evt) || (stat_q[ST_KBD] && kbd_evt));
  assign kbd_stop   = running && ctrl_q[CTL_KSTOP] && kbd_evt;

  wdt_prescale #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_pre (
    .clk(clk), .rst(rst), .clr(wr_cnt || reload_evt || kbd_stop), .run(running),
    .minute(ctrl_q[CTL_MIN]), .tick_en(tick_en), .unit_tick(unit_tick)
  );

  always_comb begin
    cnt_d  = cnt_q;
    expire = 1'b0;
    if (wr_cnt)                     cnt_d = cfg_wdata;
    else if (kbd_stop)              cnt_d = 8'd0;
    else if (reload_evt)            cnt_d = load_q;
    else if (unit_tick && running) begin
      cnt_d  = cnt_q - 8'd1;
      expire = (cnt_q == 8'd1);
    end
  end

  always_comb begin
    ctrl_d = wr_ctrl ? cfg_wdata : ctrl_q;
    stat_d = wr_stat ? cfg_wdata : stat_q;
    stat_d[ST_TRIG] = 1'b0;
    if (expire)                              trig_d = 1'b1;
    else if (wr_stat && !cfg_wdata[ST_TRIG]) trig_d = 1'b0;
    else                                     trig_d = trig_q;
  end

  always_comb begin
    case (cfg_addr)
      A_CNT:   rd_mux = cnt_q;
      A_CTRL:  rd_mux = ctrl_q;
      A_STAT:  begin rd_mux = stat_q; rd_mux[ST_TRIG] = trig_q; end
      default: rd_mux = 8'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= 8'd0;
      load_q  <= 8'd0;
      ctrl_q  <= 8'd0;
      stat_q  <= 8'd0;
      trig_q  <= 1'b0;
      wdt_n_q <= 1'b1;
      rdata_q <= 8'd0;
    end else begin
      cnt_q   <= cnt_d;
      ctrl_q  <= ctrl_d;
      stat_q  <= stat_d;
      trig_q  <= trig_d;
      wdt_n_q <= !(trig_d && !ctrl_d[CTL_PULSE]);
      if (wr_cnt) load_q  <= cfg_wdata;
      if (cfg_rd) rdata_q <= rd_mux;
    end
  end

  wdt_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
    .clk(clk), .rst(rst), .fire(expire && ctrl_q[CTL_PULSE]), .pulse_n(kbrst_n)
  );

  assign cfg_rdata = rdata_q;
  assign wdt_n     = wdt_n_q;
endmodule

// File: rtl/wdt_cfg_timer_chk.sv
module wdt_cfg_timer_chk import wdt_cfg_pkg::*; #(
  parameter int PULSE_LEN = 16
) (
  input logic       clk,
  input logic       rst,
  input logic       cfg_wr,
  input logic [7:0] cfg_addr,
  input logic [7:0] cfg_wdata,
  input logic [7:0] cnt_q,
  input logic [7:0] ctrl_q,
  input logic       trig_q,
  input logic       reload_evt,
  input logic       expire,
  input logic       wdt_n,
  input logic       kbrst_n
);
  localparam int RW = $clog2(PULSE_LEN + 2);
  logic [RW-1:0] low_run;

  always_ff @(posedge clk) begin
    if (rst || kbrst_n) low_run <= '0;
    else                low_run <= low_run + 1'b1;
  end

  assert_load_R2: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr && cfg_addr == A_CNT) |=> (cnt_q == $past(cfg_wdata)));

  assert_count_down_R3: assert property (@(posedge clk) disable iff (rst)
    (!(cfg_wr && cfg_addr == A_CNT) && !reload_evt) |=> (cnt_q <= $past(cnt_q)));

  assert_hold_zero_R4: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == 8'd0 && !(cfg_wr && cfg_addr == A_CNT)) |=> (cnt_q == 8'd0));

  assert_trig_zero_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(trig_q) |-> (cnt_q == 8'd0));

  assert_level_out_R4: assert property (@(posedge clk) disable iff (rst)
    !wdt_n |-> trig_q);

  assert_clear_R5: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr && cfg_addr == A_STAT && !cfg_wdata[ST_TRIG] && !expire) |=> !trig_q);

  assert_pulse_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    ctrl_q[CTL_PULSE] |-> wdt_n);

  assert_pulse_width_R7: assert property (@(posedge clk) disable iff (rst)
    !kbrst_n |-> (low_run < RW'(PULSE_LEN)));
endmodule

bind wdt_cfg_timer wdt_cfg_timer_chk #(.PULSE_LEN(PULSE_LEN)) u_chk (
  .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
  .cnt_q(cnt_q), .ctrl_q(ctrl_q), .trig_q(trig_q), .reload_evt(reload_evt),
  .expire(expire), .wdt_n(wdt_n), .kbrst_n(kbrst_n)
);

// File: tb/tb_wdt_cfg_timer.sv
module tb_wdt_cfg_timer;
  localparam int TPS = 3;
  localparam int PL  = 4;

  logic clk = 0, rst = 1, tick_en = 0, cfg_wr = 0, cfg_rd = 0, kbd_evt = 0, mouse_evt = 0;
  logic [7:0] cfg_addr = 0, cfg_wdata = 0;
  logic [7:0] cfg_rdata;
  logic wdt_n, kbrst_n;
  int total = 0, bad = 0;
  logic [7:0] v;

  always #2 clk = ~clk;

  wdt_cfg_timer #(.TICKS_PER_SEC(TPS), .PULSE_LEN(PL)) dut (
    .clk(clk), .rst(rst), .tick_en(tick_en), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .kbd_evt(kbd_evt), .mouse_evt(mouse_evt), .wdt_n(wdt_n), .kbrst_n(kbrst_n)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk); cfg_wr = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_wr = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [7:0] d);
    @(negedge clk); cfg_rd = 1; cfg_addr = a;
    @(negedge clk); cfg_rd = 0; d = cfg_rdata;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_en = 1;
      @(negedge clk); tick_en = 0;
    end
  endtask

  task automatic pulse_mouse();
    @(negedge clk); mouse_evt = 1; @(negedge clk); mouse_evt = 0;
  endtask

  task automatic pulse_kbd();
    @(negedge clk); kbd_evt = 1; @(negedge clk); kbd_evt = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    check("R1 wdt_n", {7'd0, wdt_n}, 8'd1);
    check("R1 kbrst_n", {7'd0, kbrst_n}, 8'd1);
    rd(8'hF6, v); check("R1 count", v, 8'h00);
    rd(8'hF5, v); check("R1 ctrl", v, 8'h00);
    rd(8'hF7, v); check("R1 stat", v, 8'h00);

    // R2 every count value loads and reads back
    for (int n = 0; n < 256; n++) begin
      wr(8'hF6, 8'(n)); rd(8'hF6, v); check("R2 load", v, 8'(n));
    end
    wr(8'hF6, 8'd0); ticks(4 * TPS);
    rd(8'hF7, v); check("R2 zero stops", v, 8'h00);
    check("R2 wdt_n", {7'd0, wdt_n}, 8'd1);

    // R3/R4/R5 run each count to expiry in level mode
    for (int n = 1; n <= 5; n++) begin
      wr(8'hF6, 8'(n));
      for (int k = 1; k < n; k++) begin
        ticks(TPS); rd(8'hF6, v); check("R3 remaining", v, 8'(n - k));
      end
      ticks(TPS - 1);
      check("R4 before expiry", {7'd0, wdt_n}, 8'd1);
      ticks(1);
      check("R4 wdt_n low", {7'd0, wdt_n}, 8'd0);
      rd(8'hF7, v); check("R4 trig", v, 8'h10);
      ticks(2 * TPS); rd(8'hF6, v); check("R4 stays zero", v, 8'h00);
      wr(8'hF7, 8'h10); rd(8'hF7, v); check("R5 write one keeps", v, 8'h10);
      check("R5 still low", {7'd0, wdt_n}, 8'd0);
      wr(8'hF7, 8'h00); rd(8'hF7, v); check("R5 cleared", v, 8'h00);
      check("R5 wdt_n high", {7'd0, wdt_n}, 8'd1);
    end

    // R8 restart resets prescaler phase
    wr(8'hF6, 8'd2); ticks(TPS - 1);
    wr(8'hF6, 8'd2); ticks(TPS - 1);
    rd(8'hF6, v); check("R8 phase reset", v, 8'd2);
    ticks(1); rd(8'hF6, v); check("R8 step", v, 8'd1);
    wr(8'hF6, 8'd0);

    // R6 minute mode
    wr(8'hF5, 8'h08); wr(8'hF6, 8'd1);
    ticks(60 * TPS - 1);
    rd(8'hF6, v); check("R6 not yet", v, 8'd1);
    rd(8'hF7, v); check("R6 no trig", v, 8'h00);
    ticks(1);
    rd(8'hF7, v); check("R6 trig", v, 8'h10);
    wr(8'hF7, 8'h00);

    // R7 pulse mode
    wr(8'hF5, 8'h02); wr(8'hF6, 8'd1); ticks(TPS - 1);
    @(negedge clk); tick_en = 1;
    @(negedge clk); tick_en = 0;
    begin
      int low = 0;
      int wlow = 0;
      while (!kbrst_n && low < 50) begin
        low++;
        if (!wdt_n) wlow++;
        @(negedge clk);
      end
      check("R7 pulse width", 8'(low), 8'(PL));
      check("R7 wdt_n quiet", 8'(wlow), 8'd0);
    end
    rd(8'hF7, v); check("R7 trig", v, 8'h10);
    wr(8'hF7, 8'h00); wr(8'hF5, 8'h00);

    // R9 event reloads
    wr(8'hF7, 8'hC0); wr(8'hF6, 8'd3);
    ticks(TPS); pulse_mouse(); rd(8'hF6, v); check("R9 mouse reload", v, 8'd3);
    ticks(TPS); pulse_kbd();   rd(8'hF6, v); check("R9 kbd reload", v, 8'd3);
    wr(8'hF7, 8'h00);
    ticks(TPS); pulse_mouse(); pulse_kbd();
    rd(8'hF6, v); check("R9 disabled ignored", v, 8'd2);
    wr(8'hF6, 8'd0);

    // R10 keyboard stop
    wr(8'hF6, 8'd5); pulse_kbd(); rd(8'hF6, v); check("R10 no stop when off", v, 8'd5);
    wr(8'hF5, 8'h04); pulse_kbd(); rd(8'hF6, v); check("R10 stopped", v, 8'd0);
    ticks(6 * TPS); rd(8'hF7, v); check("R10 no trig", v, 8'h00);
    check("R10 wdt_n", {7'd0, wdt_n}, 8'd1);

    // R11 readback
    wr(8'hF5, 8'hF1); rd(8'hF5, v); check("R11 ctrl", v, 8'hF1);
    wr(8'hF7, 8'h3F); rd(8'hF7, v); check("R11 stat", v, 8'h2F);
    wr(8'h30, 8'h55); rd(8'h30, v); check("R11 unmapped", v, 8'h00);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule